// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped controller for a parameterised number of general-purpose pins, at most 32. A host reaches it through a plain 32-bit register bus made of a byte address, a write strobe, a read strobe, write data and read data.

Each pin has a direction bit and an output level. Reading the pin-level register returns the level of every pin. Each pin also feeds an event detector that runs on a two-flop synchronised copy of the pad input. Three per-pin configuration bits select the trigger:
- level high or level low;
- rising edge or falling edge;
- any transition, when the both-edge option is built in.

Detected events collect in a raw status register. The status bits are masked by an enable register to form the pending bits, and a single interrupt line is the OR of all pending bits. Software clears status by writing ones to a separate clear register, normally writing back the pending snapshot it has just read. Setting the enable mask to zero silences the interrupt line without losing any status. Writing the earlier mask back re-raises the line for events that are still unserviced.

A version parameter is readable from the bus. The both-edge register exists only when that version is 3 or more.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input, the output levels, enable mask, edge-select and both-edge registers and all status bits are 0, every polarity bit is 1 (level-high trigger), the interrupt line is low, and the version register reads the VERSION parameter (default 3).
- R2: A direction bit of 1 makes its pin an input and 0 makes it an output; `pin_oe` is the bitwise inverse of the direction register and `pin_out` follows the written output levels; `pin_oe` changes only after a write to the direction register.
- R3: Reading the pin-level register returns the synchronised pad level for input pins and the driven level for output pins; register bits at positions N and above always read 0.
- R4: With edge-select 0 a pin is level-triggered: polarity 1 sets its status bit while the pin is high, polarity 0 while it is low, on every cycle the level is present, including the cycle after a clear.
- R5: With edge-select 1 and both-edge 0 a pin is edge-triggered: polarity 1 sets status on a 0-to-1 transition, polarity 0 on a 1-to-0 transition, and a steady level sets nothing.
- R6: With edge-select 1 and both-edge 1 any transition sets status, provided VERSION is 3 or more; with VERSION below 3 the both-edge register reads 0, ignores writes, and the pin behaves as a single-edge trigger.
- R7: Writing 1 to a bit of the clear register clears that status bit and writing 0 leaves it alone; a new event in the same cycle as its clear leaves the bit set; status bits fall only through such a write.
- R8: Pending equals status AND enable, and the interrupt line is high exactly when some pending bit is set; an all-zero enable mask holds the line low while status is kept, and restoring the mask re-raises it.
- R9: Read data is valid on the cycle after the read strobe and holds until the next read. The byte addresses are:

| Address | Register |
|---|---|
| 0x00 | pin level |
| 0x04 | direction |
| 0x08 | enable |
| 0x0C | status |
| 0x10 | pending |
| 0x14 | clear |
| 0x18 | edge-select |
| 0x1C | polarity |
| 0x20 | version |
| 0x24 | both-edge |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears the next cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | N | Pad input levels |
| pin_out | output | N | Driven output levels |
| pin_oe | output | N | Output enable per pin (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds two copies of the block with twelve pins on a shared bus and shared pads. One copy has VERSION 3 and the other VERSION 2.

Twelve pins make the zero fill above bit N and the split between input and output pins in the level readback observable. The VERSION 2 copy takes the same any-transition configuration as the VERSION 3 copy, so the bench can check that it ignores the both-edge register and reacts to a single edge only.

A vector table walks every trigger mode on pin 0, with both an active and an inactive transition for each mode. Directed tests then cover partial clears, masking and re-exposure, and a level that sets its status bit again after a clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_LEVEL  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_DIR    = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_ENABLE = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_STATUS = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_PEND   = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_CLEAR  = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_EDGE   = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_POL    = 8'h1C;
    localparam logic [BUS_AW-1:0] OFS_VER    = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_BOTH   = 8'h24;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_EDGE  = 2'd1,
        TRIG_ANY   = 2'd2
    } trig_kind_e;

    function automatic trig_kind_e trig_kind(input logic edge_sel, input logic both_sel);
        if (!edge_sel)     return TRIG_LEVEL;
        else if (both_sel) return TRIG_ANY;
        else               return TRIG_EDGE;
    endfunction

    // One pin's event: cur is the synchronised level, old the level one cycle earlier.
    function automatic logic pin_event(input logic cur, input logic old,
                                       input logic edge_sel, input logic pol,
                                       input logic both_sel);
        logic ev;
        unique case (trig_kind(edge_sel, both_sel))
            TRIG_LEVEL: ev = pol ? cur : ~cur;
            TRIG_EDGE:  ev = pol ? (cur & ~old) : (~cur & old);
            TRIG_ANY:   ev = cur ^ old;
            default:    ev = 1'b0;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] prev_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_in;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.sync;
    assign prev_o = s_q.prev;

endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
    import gpio_irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] edge_sel_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] both_i,
    output logic [N-1:0] event_o
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        assign event_o[g] = pin_event(sync_i[g], prev_i[g], edge_sel_i[g],
                                      pol_i[g], both_i[g]);
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int N       = 32,
    parameter int VERSION = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [N-1:0]      sync_i,
    input  logic [N-1:0]      event_i,
    output logic [N-1:0]      dir_o,
    output logic [N-1:0]      outv_o,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      edge_o,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      both_o,
    output logic [N-1:0]      status_o
);

    localparam bit BOTH_OK = (VERSION >= 3);

    typedef struct packed {
        logic [N-1:0]      dir;
        logic [N-1:0]      outv;
        logic [N-1:0]      en;
        logic [N-1:0]      edge_sel;
        logic [N-1:0]      pol;
        logic [N-1:0]      both;
        logic [N-1:0]      status;
        logic [BUS_DW-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic [N-1:0] wr_bits;
    logic [N-1:0] clr_mask;
    logic [N-1:0] both_next;
    logic [N-1:0] level_rb;

    function automatic logic [BUS_DW-1:0] widen(input logic [N-1:0] v);
        logic [BUS_DW-1:0] w;
        w        = '0;
        w[N-1:0] = v;
        return w;
    endfunction

    assign wr_bits  = bus_wdata[N-1:0];
    assign clr_mask = (bus_wr && bus_addr == OFS_CLEAR) ? wr_bits : '0;
    assign level_rb = (r_q.dir & sync_i) | (~r_q.dir & r_q.outv);

    if (BOTH_OK) begin : g_both
        assign both_next = (bus_wr && bus_addr == OFS_BOTH) ? wr_bits : r_q.both;
    end else begin : g_no_both
        assign both_next = '0;
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            unique case (bus_addr)
                OFS_LEVEL:  r_d.outv     = wr_bits;
                OFS_DIR:    r_d.dir      = wr_bits;
                OFS_ENABLE: r_d.en       = wr_bits;
                OFS_EDGE:   r_d.edge_sel = wr_bits;
                OFS_POL:    r_d.pol      = wr_bits;
                default:    ;
            endcase
        end
        r_d.both   = both_next;
        // a fresh event outranks a clear of the same bit
        r_d.status = (r_q.status & ~clr_mask) | event_i;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_LEVEL:  r_d.rdata = widen(level_rb);
                OFS_DIR:    r_d.rdata = widen(r_q.dir);
                OFS_ENABLE: r_d.rdata = widen(r_q.en);
                OFS_STATUS: r_d.rdata = widen(r_q.status);
                OFS_PEND:   r_d.rdata = widen(r_q.status & r_q.en);
                OFS_EDGE:   r_d.rdata = widen(r_q.edge_sel);
                OFS_POL:    r_d.rdata = widen(r_q.pol);
                OFS_VER:    r_d.rdata = 32'(VERSION);
                OFS_BOTH:   r_d.rdata = widen(r_q.both);
                default:    r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.dir      <= '1;
            r_q.pol      <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;
    assign dir_o     = r_q.dir;
    assign outv_o    = r_q.outv;
    assign en_o      = r_q.en;
    assign edge_o    = r_q.edge_sel;
    assign pol_o     = r_q.pol;
    assign both_o    = r_q.both;
    assign status_o  = r_q.status;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int N       = 32,
    parameter int VERSION = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic              irq
);

    logic [N-1:0] sync_w, prev_w, event_w;
    logic [N-1:0] dir_w, outv_w, en_w, edge_w, pol_w, both_w, status_w;

    gpio_sync #(.N(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    gpio_trig #(.N(N)) u_trig (
        .sync_i     (sync_w),
        .prev_i     (prev_w),
        .edge_sel_i (edge_w),
        .pol_i      (pol_w),
        .both_i     (both_w),
        .event_o    (event_w)
    );

    gpio_regs #(.N(N), .VERSION(VERSION)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_i    (sync_w),
        .event_i   (event_w),
        .dir_o     (dir_w),
        .outv_o    (outv_w),
        .en_o      (en_w),
        .edge_o    (edge_w),
        .pol_o     (pol_w),
        .both_o    (both_w),
        .status_o  (status_w)
    );

    assign pin_out = outv_w;
    assign pin_oe  = ~dir_w;
    assign irq     = |(status_w & en_w);

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int N       = 32,
    parameter int VERSION = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic [N-1:0]      pin_oe,
    input logic              irq,
    input logic [N-1:0]      status,
    input logic [N-1:0]      enable
);

    // R7
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |-> $past(bus_wr && bus_addr == OFS_CLEAR));

    // R2
    oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr && bus_addr == OFS_DIR) |-> $stable(pin_oe));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));

    // R8
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|status));

    // R6
    both_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((VERSION < 3) && $past(bus_rd && bus_addr == OFS_BOTH)) |-> (bus_rdata == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.N(N), .VERSION(VERSION)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .status    (status_w),
    .enable    (en_w)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    import gpio_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 12;
    localparam logic [NP-1:0] ALL = '1;

    // {edge_sel, pol, both, start level, end level, expected status}
    localparam int NVEC = 11;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b010_01_1, 6'b010_00_0, 6'b000_10_1, 6'b000_11_0,
        6'b110_01_1, 6'b110_10_0, 6'b100_10_1, 6'b100_01_0,
        6'b111_01_1, 6'b101_10_1, 6'b110_11_0
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [BUS_AW-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [BUS_DW-1:0] bus_wdata = '0;
    logic [BUS_DW-1:0] rdata, rdata2;
    logic [NP-1:0]     pin_in = '0;
    logic [NP-1:0]     pin_out, pin_oe, pin_out2, pin_oe2;
    logic              irq, irq2;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rv, rv2;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl #(.N(NP), .VERSION(3)) i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    gpio_irq_ctrl #(.N(NP), .VERSION(2)) i_gpio_irq_ctrl_v2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
        .pin_in(pin_in), .pin_out(pin_out2), .pin_oe(pin_oe2), .irq(irq2)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [BUS_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [BUS_AW-1:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        rv = rdata; rv2 = rdata2;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pin_oe", {20'b0, pin_oe}, 32'h0);
        bus_read(OFS_DIR);    check("R1 dir", rv, 32'hFFF);
        bus_read(OFS_LEVEL);  check("R1 level", rv, 32'h0);
        bus_read(OFS_ENABLE); check("R1 enable", rv, 32'h0);
        bus_read(OFS_STATUS); check("R1 status", rv, 32'h0);
        bus_read(OFS_POL);    check("R1 polarity", rv, 32'hFFF);
        bus_read(OFS_EDGE);   check("R1 edge", rv, 32'h0);
        bus_read(OFS_VER);    check("R1 version", rv, 32'd3);

        // trigger-mode table on pin 0
        bus_write(OFS_ENABLE, 32'h1);
        for (int i = 0; i < NVEC; i++) begin
            logic [5:0] v;
            string tag;
            v = VEC[i];
            tag = !v[5] ? "R4 level" : (v[3] ? "R6 any-edge" : "R5 edge");
            bus_write(OFS_EDGE, {20'b0, {NP{v[5]}}});
            bus_write(OFS_POL,  {20'b0, {NP{v[4]}}});
            bus_write(OFS_BOTH, {20'b0, {NP{v[3]}}});
            pin_in = '0; pin_in[0] = v[2];
            settle();
            bus_write(OFS_CLEAR, 32'hFFF);
            pin_in[0] = v[1];
            settle();
            bus_read(OFS_STATUS);
            check(tag, {31'b0, rv[0]}, {31'b0, v[0]});
            check({tag, " R8 irq"}, {31'b0, irq}, {31'b0, v[0]});
        end

        // R2 / R3 direction and level readback
        bus_write(OFS_BOTH, 32'h0);
        bus_write(OFS_EDGE, 32'h0);
        bus_write(OFS_POL, 32'hFFF);
        bus_write(OFS_ENABLE, 32'h0);
        bus_write(OFS_DIR, 32'h00F);
        bus_write(OFS_LEVEL, 32'hA5A);
        pin_in = 12'h3C3;
        settle();
        check("R2 pin_oe", {20'b0, pin_oe}, 32'hFF0);
        check("R2 pin_out", {20'b0, pin_out}, 32'hA5A);
        bus_read(OFS_LEVEL); check("R3 mixed readback", rv, 32'hA53);
        bus_write(OFS_DIR, 32'hFFFF_FFFF);
        bus_read(OFS_DIR); check("R3 upper bits zero", rv, 32'hFFF);
        bus_read(OFS_LEVEL); check("R3 input readback", rv, 32'h3C3);

        // R5 / R7 / R8 rising edges, partial clear, masking
        pin_in = '0;
        bus_write(OFS_EDGE, 32'hFFF);
        settle();
        bus_write(OFS_CLEAR, 32'hFFF);
        bus_read(OFS_STATUS); check("R7 clear all", rv, 32'h0);
        pin_in = 12'h006;
        settle();
        bus_read(OFS_STATUS); check("R5 two rising pins", rv, 32'h006);
        bus_write(OFS_CLEAR, 32'h002);
        bus_read(OFS_STATUS); check("R7 partial clear", rv, 32'h004);
        bus_write(OFS_ENABLE, 32'h00F);
        @(negedge clk);
        check("R8 irq enabled", {31'b0, irq}, 32'h1);
        bus_read(OFS_PEND); check("R8 pending", rv, 32'h004);
        bus_write(OFS_ENABLE, 32'h0);
        @(negedge clk);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        bus_read(OFS_PEND); check("R8 pending masked", rv, 32'h0);
        bus_read(OFS_STATUS); check("R8 status kept", rv, 32'h004);
        bus_write(OFS_ENABLE, 32'h00F);
        @(negedge clk);
        check("R8 irq restored", {31'b0, irq}, 32'h1);

        // R4 / R7 level re-asserts after clear
        bus_write(OFS_EDGE, 32'h0);
        settle();
        bus_write(OFS_CLEAR, 32'hFFF);
        bus_read(OFS_STATUS); check("R4 level survives clear", rv, 32'h006);
        pin_in = '0;
        settle();
        bus_write(OFS_CLEAR, 32'hFFF);
        bus_read(OFS_STATUS); check("R4 level inactive", rv, 32'h0);
        bus_write(OFS_POL, 32'h0);
        settle();
        bus_read(OFS_STATUS); check("R4 active low", rv, 32'hFFF);

        // R6 both-edge only with VERSION >= 3
        bus_read(OFS_VER); check("R1 version v2 copy", rv2, 32'd2);
        bus_write(OFS_BOTH, 32'hFFF);
        bus_read(OFS_BOTH);
        check("R6 both reg v3", rv, 32'hFFF);
        check("R6 both reg v2", rv2, 32'h0);
        bus_write(OFS_EDGE, 32'hFFF);
        bus_write(OFS_POL, 32'hFFF);
        pin_in = 12'h001;
        settle();
        bus_write(OFS_CLEAR, 32'hFFF);
        pin_in = '0;
        settle();
        bus_read(OFS_STATUS);
        check("R6 falling with both v3", rv, 32'h001);
        check("R6 falling ignored v2", rv2, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule